// File: doc/BRIEF.md
# Data Rate Search Sequencer

This block is the slow control side of a serial clock-recovery loop. It runs from a low-rate system clock with no relation to the data rate. It chooses the divider modulus and the oscillator band that the analog loop should use. It also runs one frequency-acquisition attempt after another, and each attempt sweeps upward first and then downward. In automatic mode a 3-bit rate counter steps to the next valid code after every attempt that ends without lock, and the current code is shown on the rate output. In manual mode the code comes from an input and the counter never moves.

A standard-select input changes how codes map to moduli. When input data is lost, the counter keeps its value, so acquisition resumes at the code that last held lock. The `tick` input is a one-cycle enable that marks each system-clock period. All sweep timing is counted in ticks.

Top module: `rate_search_seq`

## Requirements
- R1: In automatic mode (`auto_mode`=1) the rate code takes only the values 0 to 4. It advances by one at the end of each attempt that finishes without lock, wrapping from 4 to 0, and it is 0 after reset.
- R2: With `std_sel`=1, codes 0,1,2,3,4 give `div_mod` 4,2,2,1,1. `div_mod` carries the modulus value itself, and 0 means no valid modulus.
- R3: With `std_sel`=0, codes 0,1,2,3,4 give `div_mod` 4,4,2,2,1.
- R4: `band_low`=1 (low oscillator band) only when `std_sel`=1, bit 0 of the code is 1 and the code is valid. Every other case selects the high band (`band_low`=0).
- R5: In manual mode `rate_code` follows `man_code` and never steps across attempts. Code 6 gives modulus 8. Code 5 gives modulus 8 with `std_sel`=1 and modulus 1 with `std_sel`=0.
- R6: Manual code 7 is invalid. From the next clock it forces an idle state with `sweep_on`=0 and gives `div_mod`=0. Once the code is valid, the next tick starts an upward sweep.
- R7: An attempt lasts SWEEP_LEN ticks with `sweep_up`=1, then SWEEP_LEN ticks sweeping down (`sweep_on`=1, `sweep_up`=0), then one gap tick with `sweep_on`=0. `cycle_end` is high during that gap tick, and the next attempt then starts upward.
- R8: `lock_i` high at a tick during either sweep direction ends the sweep (`sweep_on`=0) and holds the code. Lock lost at a later tick restarts an upward sweep at the same code.
- R9: `data_ok`=0 stops the sweep from the next clock and freezes the rate code. `cycle_end` stays low meanwhile. The first tick after data returns starts an upward sweep at the frozen code.
- R10: After reset the sweep sits at the start of its upward phase (`sweep_up`=1) with `cycle_end`=0. No state changes between ticks except for the forced entries of R6 and R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable per system period |
| lock_i | input | 1 | Loop reports lock |
| data_ok | input | 1 | Input data transitions present |
| auto_mode | input | 1 | 1 = automatic rate search, 0 = manual |
| std_sel | input | 1 | Selects the rate mapping family |
| man_code | input | 3 | Manual rate code |
| div_mod | output | 4 | Divider modulus value (1,2,4,8; 0 = invalid) |
| band_low | output | 1 | 1 = low oscillator band |
| sweep_on | output | 1 | A sweep is in progress |
| sweep_up | output | 1 | Sweep direction is upward |
| cycle_end | output | 1 | Attempt boundary, high in the gap tick |
| rate_code | output | 3 | Current rate code |

## Verification
The hardest case is a data loss that arrives after the counter has already moved off zero and in the middle of a sweep. To check it, the bench has to show that the frozen code holds through many ticks and that the search resumes there, not at zero. The bench gets there by running whole failed attempts until the counter reaches a chosen code. It then drops data partway through the sweep, applies more ticks than a full attempt takes, and restores data. Lock is applied the same way in both sweep directions. The wrap from 4 to 0 is covered by running two complete laps of the counter under each mapping family.

// File: rtl/rss_pkg.sv
package rss_pkg;
  localparam int RSS_CODE_W = 3;
  localparam int RSS_MOD_W  = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HOLD = 3'd1,
    ST_UP   = 3'd2,
    ST_DOWN = 3'd3,
    ST_GAP  = 3'd4,
    ST_LOCK = 3'd5
  } rss_state_e;
endpackage

// File: rtl/rss_rate_ctr.sv
module rss_rate_ctr #(
  parameter int CODE_W    = 3,
  parameter int NUM_CODES = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [CODE_W-1:0] code
);
  localparam logic [CODE_W-1:0] LAST_CODE = CODE_W'(NUM_CODES - 1);

  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (adv) begin
      if (code_q >= LAST_CODE) code_d = '0;
      else                     code_d = code_q + CODE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   code_q <= '0;
    else if (adv) code_q <= code_d;
  end

  assign code = code_q;
endmodule

// File: rtl/rss_sweep_fsm.sv
module rss_sweep_fsm
  import rss_pkg::*;
#(
  parameter int SWEEP_LEN = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       lock_i,
  input  logic       data_ok,
  input  logic       halt,
  output rss_state_e state,
  output logic       attempt_end
);
  localparam int SW_W = (SWEEP_LEN > 1) ? $clog2(SWEEP_LEN) : 1;
  localparam logic [SW_W-1:0] SW_LAST = SW_W'(SWEEP_LEN - 1);

  rss_state_e      st_q, st_d;
  logic [SW_W-1:0] sw_q, sw_d;
  logic            en;

  always_comb begin
    st_d = st_q;
    sw_d = sw_q;
    if (halt) begin
      st_d = ST_IDLE;
    end else if (!data_ok) begin
      st_d = ST_HOLD;
    end else if (tick) begin
      case (st_q)
        ST_IDLE, ST_HOLD: begin
          st_d = ST_UP;
          sw_d = '0;
        end
        ST_UP: begin
          if (lock_i) st_d = ST_LOCK;
          else if (sw_q == SW_LAST) begin
            st_d = ST_DOWN;
            sw_d = '0;
          end else sw_d = sw_q + SW_W'(1);
        end
        ST_DOWN: begin
          if (lock_i) st_d = ST_LOCK;
          else if (sw_q == SW_LAST) st_d = ST_GAP;
          else sw_d = sw_q + SW_W'(1);
        end
        ST_GAP: begin
          st_d = ST_UP;
          sw_d = '0;
        end
        ST_LOCK: begin
          if (!lock_i) begin
            st_d = ST_UP;
            sw_d = '0;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  assign en = halt || !data_ok || tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_UP;
      sw_q <= '0;
    end else if (en) begin
      st_q <= st_d;
      sw_q <= sw_d;
    end
  end

  assign state       = st_q;
  assign attempt_end = tick && data_ok && !halt && (st_q == ST_GAP);
endmodule

// File: rtl/rss_rate_map.sv
module rss_rate_map #(
  parameter int CODE_W = 3,
  parameter int MOD_W  = 4
) (
  input  logic              std_sel,
  input  logic              manual,
  input  logic [CODE_W-1:0] code,
  output logic [MOD_W-1:0]  div_mod,
  output logic              band_low
);
  always_comb begin
    case (code)
      CODE_W'(0): div_mod = MOD_W'(4);
      CODE_W'(1): div_mod = std_sel ? MOD_W'(2) : MOD_W'(4);
      CODE_W'(2): div_mod = MOD_W'(2);
      CODE_W'(3): div_mod = std_sel ? MOD_W'(1) : MOD_W'(2);
      CODE_W'(4): div_mod = MOD_W'(1);
      CODE_W'(5): div_mod = !manual ? '0 : (std_sel ? MOD_W'(8) : MOD_W'(1));
      CODE_W'(6): div_mod = manual ? MOD_W'(8) : '0;
      default:    div_mod = '0;
    endcase
  end

  assign band_low = std_sel && code[0] && (div_mod != '0);
endmodule

// File: rtl/rate_search_seq.sv
module rate_search_seq
  import rss_pkg::*;
#(
  parameter int SWEEP_LEN = 16,
  parameter int NUM_CODES = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  lock_i,
  input  logic                  data_ok,
  input  logic                  auto_mode,
  input  logic                  std_sel,
  input  logic [RSS_CODE_W-1:0] man_code,
  output logic [RSS_MOD_W-1:0]  div_mod,
  output logic                  band_low,
  output logic                  sweep_on,
  output logic                  sweep_up,
  output logic                  cycle_end,
  output logic [RSS_CODE_W-1:0] rate_code
);
  localparam logic [RSS_CODE_W-1:0] BAD_CODE = '1;

  logic                  rst_m, rst_sync_n;
  logic                  bad_man, att_end, adv;
  logic [RSS_CODE_W-1:0] auto_code;
  rss_state_e            st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m      <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_m      <= 1'b1;
      rst_sync_n <= rst_m;
    end
  end

  assign bad_man = !auto_mode && (man_code == BAD_CODE);
  assign adv     = att_end && auto_mode;

  rss_rate_ctr #(.CODE_W(RSS_CODE_W), .NUM_CODES(NUM_CODES)) u_ctr (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .adv   (adv),
    .code  (auto_code)
  );

  rss_sweep_fsm #(.SWEEP_LEN(SWEEP_LEN)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .tick        (tick),
    .lock_i      (lock_i),
    .data_ok     (data_ok),
    .halt        (bad_man),
    .state       (st),
    .attempt_end (att_end)
  );

  assign rate_code = auto_mode ? auto_code : man_code;

  rss_rate_map #(.CODE_W(RSS_CODE_W), .MOD_W(RSS_MOD_W)) u_map (
    .std_sel  (std_sel),
    .manual   (!auto_mode),
    .code     (rate_code),
    .div_mod  (div_mod),
    .band_low (band_low)
  );

  assign sweep_on  = (st == ST_UP) || (st == ST_DOWN);
  assign sweep_up  = (st == ST_UP);
  assign cycle_end = att_end;
endmodule

// File: rtl/rss_checker.sv
module rss_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       lock_i,
  input logic       data_ok,
  input logic       auto_mode,
  input logic       std_sel,
  input logic [2:0] man_code,
  input logic [3:0] div_mod,
  input logic       band_low,
  input logic       sweep_on,
  input logic       sweep_up,
  input logic       cycle_end,
  input logic [2:0] rate_code
);
  logic bad;
  assign bad = !auto_mode && (man_code == 3'd7);

  AST_AUTO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    auto_mode |-> rate_code <= 3'd4); // R1

  AST_CODE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && $past(auto_mode) && $past(cycle_end))
      |-> rate_code == (($past(rate_code) == 3'd4) ? 3'd0 : $past(rate_code) + 3'd1)); // R1

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && $past(auto_mode) && !$past(cycle_end)) |-> $stable(rate_code)); // R9

  AST_BAND_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    band_low |-> (std_sel && rate_code[0])); // R4

  AST_MOD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(div_mod)); // R2

  AST_BAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> !sweep_on); // R6

  AST_LOCK_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick) && $past(lock_i) && $past(sweep_on) && $past(data_ok) && !$past(bad))
      |-> !sweep_on); // R8

  AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ok |-> !cycle_end); // R9

  AST_UP_IS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_up |-> sweep_on); // R7
endmodule

bind rate_search_seq rss_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .tick      (tick),
  .lock_i    (lock_i),
  .data_ok   (data_ok),
  .auto_mode (auto_mode),
  .std_sel   (std_sel),
  .man_code  (man_code),
  .div_mod   (div_mod),
  .band_low  (band_low),
  .sweep_on  (sweep_on),
  .sweep_up  (sweep_up),
  .cycle_end (cycle_end),
  .rate_code (rate_code)
);

// File: tb/tb_rate_search_seq.sv
module tb_rate_search_seq;
  localparam int L = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, lock_i = 1'b0, data_ok = 1'b1;
  logic       auto_mode = 1'b1, std_sel = 1'b1;
  logic [2:0] man_code = 3'd0;
  logic [3:0] div_mod;
  logic       band_low, sweep_on, sweep_up, cycle_end;
  logic [2:0] rate_code;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic ce_seen;

  always #4 clk = ~clk;

  rate_search_seq #(.SWEEP_LEN(L)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .lock_i(lock_i), .data_ok(data_ok),
    .auto_mode(auto_mode), .std_sel(std_sel), .man_code(man_code),
    .div_mod(div_mod), .band_low(band_low), .sweep_on(sweep_on),
    .sweep_up(sweep_up), .cycle_end(cycle_end), .rate_code(rate_code)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int emod(bit s, int c, bit man);
    if (c <= 4) return s ? (4 >> ((c + 1) / 2)) : (4 >> (c / 2));
    if (c == 5) return man ? (s ? 8 : 1) : 0;
    if (c == 6) return man ? 8 : 0;
    return 0;
  endfunction

  function automatic int eband(bit s, int c, bit man);
    return (s && (c % 2 == 1) && emod(s, c, man) != 0) ? 1 : 0;
  endfunction

  task automatic clk1();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic tk();
    tick = 1'b1; #1 ce_seen = cycle_end;
    @(posedge clk); @(negedge clk); tick = 1'b0; #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; tick = 0; lock_i = 0; data_ok = 1;
    clk1(); clk1();
    rst_n = 1'b1;
    clk1(); clk1(); clk1();
  endtask

  task automatic check_map(string req);
    chk(req, div_mod, emod(std_sel, rate_code, !auto_mode));
    chk("R4", band_low, eband(std_sel, rate_code, !auto_mode));
  endtask

  // one full failed attempt; exp_code is code before, checks code after
  task automatic run_attempt(int exp_code, bit auto_on);
    for (int i = 0; i < L; i++) begin
      chk("R7 up", sweep_up, 1);
      chk("R7 code", rate_code, exp_code);
      tk();
    end
    for (int i = 0; i < L; i++) begin
      chk("R7 down", {sweep_on, sweep_up}, 2'b10);
      tk();
    end
    chk("R7 gap", sweep_on, 0);
    tk();
    chk("R7 cycle_end", ce_seen, 1);
    chk("R7 restart", sweep_up, 1);
    if (auto_on) chk("R1 step", rate_code, (exp_code == 4) ? 0 : exp_code + 1);
    else chk("R5 no step", rate_code, exp_code);
  endtask

  initial begin
    do_reset();
    chk("R10 code", rate_code, 0);
    chk("R10 up", sweep_up, 1);
    chk("R10 on", sweep_on, 1);
    chk("R10 ce", cycle_end, 0);
    for (int i = 0; i < 10; i++) clk1();
    chk("R10 no tick", sweep_up, 1);

    // automatic laps, both families
    for (int s = 1; s >= 0; s--) begin
      std_sel = s[0];
      do_reset();
      for (int a = 0; a < 10; a++) begin
        check_map(s ? "R2" : "R3");
        run_attempt(a % 5, 1'b1);
      end
    end

    // manual sweep over all codes
    auto_mode = 0;
    for (int s = 0; s < 2; s++) begin
      std_sel = s[0];
      for (int c = 0; c < 8; c++) begin
        do_reset();
        man_code = c[2:0];
        clk1();
        chk("R5 code", rate_code, c);
        check_map(c == 7 ? "R6" : "R5");
        if (c == 7) begin
          chk("R6 idle", sweep_on, 0);
          tk(); tk();
          chk("R6 idle tick", sweep_on, 0);
          man_code = 3'd5;
          clk1();
          chk("R6 still idle", sweep_on, 0);
          tk();
          chk("R6 restart", sweep_up, 1);
        end else begin
          run_attempt(c, 1'b0);
          chk("R5 fixed mod", div_mod, emod(s[0], c, 1'b1));
        end
      end
    end

    // lock in both directions
    auto_mode = 1; std_sel = 1;
    do_reset();
    run_attempt(0, 1'b1);
    run_attempt(1, 1'b1);
    tk();
    lock_i = 1; tk();
    chk("R8 stop up", sweep_on, 0);
    tk(); tk(); tk();
    chk("R8 held", sweep_on, 0);
    chk("R8 code", rate_code, 2);
    lock_i = 0; tk();
    chk("R8 relock up", sweep_up, 1);
    chk("R8 code kept", rate_code, 2);
    for (int i = 0; i < L; i++) tk();
    chk("R7 in down", {sweep_on, sweep_up}, 2'b10);
    lock_i = 1; tk();
    chk("R8 stop down", sweep_on, 0);
    lock_i = 0; tk();
    chk("R8 restart", sweep_up, 1);

    // data loss mid sweep at code 2
    tk();
    data_ok = 0; clk1();
    chk("R9 stop", sweep_on, 0);
    for (int i = 0; i < 2 * L + 5; i++) begin
      tk();
      chk("R9 no edge", ce_seen, 0);
    end
    chk("R9 frozen", rate_code, 2);
    data_ok = 1; clk1(); clk1();
    chk("R9 wait tick", sweep_on, 0);
    tk();
    chk("R9 resume up", sweep_up, 1);
    chk("R9 resume code", rate_code, 2);
    run_attempt(2, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule